// File: doc/BRIEF.md
# Reset Cause Controller

This block merges six reset causes into one synchronous chip reset and records, in a byte-wide status register, which causes have fired. The causes are a power-on detect, a brownout detect that a power-down control can switch off, an active-low external reset pin with an enable, a watchdog reset with an enable, a software reset bit, and a serial-break reset with an enable. The analog detectors, the watchdog counter and the break detector are outside the block. Each arrives as a single-bit level.

The external pin and the three detector levels each pass through a synchronizer chain. After the last clock edge at which any gated request is seen, the chip reset output stays high for a fixed number of cycles. The power-on detect is the block's own asynchronous reset. While it is high the chip reset is held high, and after it falls the chip reset stays high for the same stretch.

Software reaches the block through a two-register port. Register select 0 is the cause register and select 1 is the control register. Status flags are sticky across every reset except power-on. A flag is cleared only by writing 0 to its bit, and a flag that is being set in the same cycle stays set.

Top module: `rst_cause_ctrl`

## Requirements
- R1: While `pwr_on_i` is high, `chip_rst_o` is 1, the cause register reads 0x30 and the control register reads 0x00. The power-on flag (bit 4) is never set by anything else.
- R2: Cause register bit layout: bit 0 external pin, bit 1 software, bit 2 watchdog, bit 3 break, bit 4 power-on, bit 5 brownout. Bits 7:6 always read 0, and writes to them have no effect.
- R3: The pin (`pin_rst_n_i` low) causes a reset and sets bit 0 only when `pin_rst_en_i` is 1. If the pin is still low when power-on ends and the enable is 1, bit 0 is set.
- R4: `wdog_i` causes a reset and sets bit 2 only when `wdog_en_i` is 1.
- R5: `brk_rst_i` causes a reset and sets bit 3 only when `brk_rst_en_i` is 1.
- R6: `brownout_i` causes a reset and sets bit 5 only when `brownout_off_i` is 0.
- R7: Writing 1 to control bit 0 reads back 1 for one cycle. On the next edge it clears itself, the chip reset begins and cause bit 1 is set.
- R8: Any reset other than power-on leaves earlier flags set, so several flags can be set at once.
- R9: A write of value W to the cause register clears every flag whose bit in W is 0 and leaves every flag whose bit in W is 1 unchanged.
- R10: When a flag's cause is active in the same cycle as a write that would clear that flag, the flag stays set.
- R11: An external or detector request reaches the chip reset on the third edge after it changes (two-stage synchronizer). `chip_rst_o` then stays 1 for exactly `STRETCH_CYCLES` (default 16) cycles after the last edge that saw any gated request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_on_i | input | 1 | Power-on detect, active high, asynchronous; the block's own reset |
| brownout_i | input | 1 | Brownout detect level |
| brownout_off_i | input | 1 | 1 stops brownout from causing a reset |
| pin_rst_n_i | input | 1 | External reset pin, active low |
| pin_rst_en_i | input | 1 | 1 lets the pin cause a reset |
| wdog_i | input | 1 | Watchdog reset request |
| wdog_en_i | input | 1 | 1 lets the watchdog cause a reset |
| brk_rst_i | input | 1 | Serial break-detect reset request |
| brk_rst_en_i | input | 1 | 1 lets break detect cause a reset |
| reg_sel_i | input | 1 | Register select: 0 cause register, 1 control register |
| reg_we_i | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register (combinational) |
| chip_rst_o | output | 1 | Stretched chip reset, active high |

## Verification
The assertions assume that `pwr_on_i` is high from time zero, because they use it as their disable condition. They also assume the enables and the brownout power-down control are quasi-static configuration levels that do not change while the matching request is active. The bench meets both conditions. It starts in power-on and changes gating only at negative edges between fully drained resets. It holds each request for one whole clock period, so every synchronizer stage sees it cleanly.

// File: rtl/rst_cause_pkg.sv
`timescale 1ns/1ps
package rst_cause_pkg;
  // cause register bit positions (software decodes these)
  localparam int F_EXT = 0;
  localparam int F_SW  = 1;
  localparam int F_WDT = 2;
  localparam int F_BRK = 3;
  localparam int F_POF = 4;
  localparam int F_BOF = 5;
  localparam int NUM_FLAGS = 6;
  localparam int REG_W = 8;

  // synchronized request lanes
  localparam int L_EXT = 0;
  localparam int L_WDT = 1;
  localparam int L_BRK = 2;
  localparam int L_BOD = 3;
  localparam int NUM_LANES = 4;

  localparam logic SEL_CAUSE = 1'b0;
  localparam logic SEL_CTRL  = 1'b1;
  localparam int   CTRL_SWRST = 0;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
  typedef logic [NUM_LANES-1:0] lane_vec_t;

  localparam flag_vec_t FLAGS_AT_POWER_ON = flag_vec_t'((1 << F_POF) | (1 << F_BOF));
endpackage

// File: rtl/rcc_sync_bank.sv
`timescale 1ns/1ps
module rcc_sync_bank #(
  parameter int LANES  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] d,
  output logic [LANES-1:0] q
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or posedge rst) begin
      if (rst) chain <= '0;
      else if (STAGES == 1) chain <= d[l];
      else chain <= {chain[STAGES-2:0], d[l]};
    end
    assign q[l] = chain[STAGES-1];
  end
endmodule

// File: rtl/rcc_req_gate.sv
`timescale 1ns/1ps
module rcc_req_gate
  import rst_cause_pkg::*;
(
  input  lane_vec_t lane,
  input  logic      pin_en,
  input  logic      wdog_en,
  input  logic      brk_en,
  input  logic      bod_off,
  input  logic      sw_bit,
  output flag_vec_t ev,
  output logic      any_req
);
  always_comb begin
    ev        = '0;
    ev[F_EXT] = lane[L_EXT] & pin_en;
    ev[F_SW]  = sw_bit;
    ev[F_WDT] = lane[L_WDT] & wdog_en;
    ev[F_BRK] = lane[L_BRK] & brk_en;
    ev[F_BOF] = lane[L_BOD] & ~bod_off;
    any_req   = |ev;
  end
endmodule

// File: rtl/rcc_stretch.sv
`timescale 1ns/1ps
module rcc_stretch #(
  parameter int STRETCH = 16,
  parameter int CNT_W   = $clog2(STRETCH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_req,
  output logic [CNT_W-1:0] cnt,
  output logic             chip_rst
);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH);

  always_ff @(posedge clk or posedge rst) begin
    if (rst)              cnt <= LOAD;
    else if (any_req)     cnt <= LOAD;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign chip_rst = (cnt != '0);
endmodule

// File: rtl/rcc_cause_reg.sv
`timescale 1ns/1ps
module rcc_cause_reg
  import rst_cause_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  flag_vec_t        ev,
  input  logic             sel,
  input  logic             we,
  input  logic [REG_W-1:0] wdata,
  output flag_vec_t        flags,
  output logic             sw_bit,
  output logic [REG_W-1:0] rdata
);
  flag_vec_t clr;

  always_comb begin
    clr = '0;
    if (we && sel == SEL_CAUSE) clr = ~wdata[NUM_FLAGS-1:0];
  end

  // set has priority over a clear in the same cycle
  always_ff @(posedge clk or posedge rst) begin
    if (rst) flags <= FLAGS_AT_POWER_ON;
    else     flags <= (flags & ~clr) | ev;
  end

  // software reset bit lives for one cycle, then clears itself
  always_ff @(posedge clk or posedge rst) begin
    if (rst)         sw_bit <= 1'b0;
    else if (sw_bit) sw_bit <= 1'b0;
    else if (we && sel == SEL_CTRL) sw_bit <= wdata[CTRL_SWRST];
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_CAUSE) rdata[NUM_FLAGS-1:0] = flags;
    else                  rdata[CTRL_SWRST]    = sw_bit;
  end
endmodule

// File: rtl/rst_cause_ctrl.sv
`timescale 1ns/1ps
module rst_cause_ctrl
  import rst_cause_pkg::*;
#(
  parameter int SYNC_STAGES    = 2,
  parameter int STRETCH_CYCLES = 16
) (
  input  logic             clk,
  input  logic             pwr_on_i,
  input  logic             brownout_i,
  input  logic             brownout_off_i,
  input  logic             pin_rst_n_i,
  input  logic             pin_rst_en_i,
  input  logic             wdog_i,
  input  logic             wdog_en_i,
  input  logic             brk_rst_i,
  input  logic             brk_rst_en_i,
  input  logic             reg_sel_i,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             chip_rst_o
);
  localparam int CNT_W = $clog2(STRETCH_CYCLES + 1);

  lane_vec_t        lane_raw, lane;
  flag_vec_t        ev, flags;
  logic             any_req, sw_bit;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    lane_raw        = '0;
    lane_raw[L_EXT] = ~pin_rst_n_i;
    lane_raw[L_WDT] = wdog_i;
    lane_raw[L_BRK] = brk_rst_i;
    lane_raw[L_BOD] = brownout_i;
  end

  rcc_sync_bank #(.LANES(NUM_LANES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(pwr_on_i), .d(lane_raw), .q(lane)
  );

  rcc_req_gate u_gate (
    .lane(lane), .pin_en(pin_rst_en_i), .wdog_en(wdog_en_i),
    .brk_en(brk_rst_en_i), .bod_off(brownout_off_i), .sw_bit(sw_bit),
    .ev(ev), .any_req(any_req)
  );

  rcc_stretch #(.STRETCH(STRETCH_CYCLES), .CNT_W(CNT_W)) u_stretch (
    .clk(clk), .rst(pwr_on_i), .any_req(any_req), .cnt(cnt), .chip_rst(chip_rst_o)
  );

  rcc_cause_reg u_regs (
    .clk(clk), .rst(pwr_on_i), .ev(ev), .sel(reg_sel_i), .we(reg_we_i),
    .wdata(reg_wdata_i), .flags(flags), .sw_bit(sw_bit), .rdata(reg_rdata_o)
  );
endmodule

// File: rtl/rst_cause_chk.sv
`timescale 1ns/1ps
module rst_cause_chk
  import rst_cause_pkg::*;
#(
  parameter int STRETCH = 16,
  parameter int CNT_W   = 5
) (
  input logic             clk,
  input logic             por,
  input logic             any_req,
  input logic             sw_bit,
  input flag_vec_t        ev,
  input flag_vec_t        flags,
  input logic [CNT_W-1:0] cnt,
  input logic             we,
  input logic             sel,
  input logic [REG_W-1:0] wdata,
  input logic [1:0]       rdata_hi,
  input logic             chip_rst
);
  assert_req_loads_R11: assert property (@(posedge clk) disable iff (por)
    any_req |=> (chip_rst && cnt == CNT_W'(STRETCH)));

  assert_countdown_R11: assert property (@(posedge clk) disable iff (por)
    (!any_req && cnt != '0) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  assert_idle_R11: assert property (@(posedge clk) disable iff (por)
    (!any_req && cnt == '0) |=> !chip_rst);

  assert_sw_pulse_R7: assert property (@(posedge clk) disable iff (por)
    sw_bit |=> !sw_bit);

  assert_sw_flag_R7: assert property (@(posedge clk) disable iff (por)
    sw_bit |=> flags[F_SW]);

  assert_pof_only_por_R1: assert property (@(posedge clk) disable iff (por)
    !flags[F_POF] |=> !flags[F_POF]);

  assert_reserved_R2: assert property (@(posedge clk) disable iff (por)
    (sel == SEL_CAUSE) |-> (rdata_hi == 2'b00));

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (por)
      ev[i] |=> flags[i]);
    assert_sticky_R8: assert property (@(posedge clk) disable iff (por)
      (flags[i] && !(we && sel == SEL_CAUSE && !wdata[i])) |=> flags[i]);
  end
endmodule

bind rst_cause_ctrl rst_cause_chk #(.STRETCH(STRETCH_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .por(pwr_on_i), .any_req(any_req), .sw_bit(sw_bit), .ev(ev),
  .flags(flags), .cnt(cnt), .we(reg_we_i), .sel(reg_sel_i), .wdata(reg_wdata_i),
  .rdata_hi(reg_rdata_o[7:6]), .chip_rst(chip_rst_o)
);

// File: tb/tb_rst_cause_ctrl.sv
`timescale 1ns/1ps
module tb_rst_cause_ctrl;
  localparam int STRETCH = 16;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic bod = 1'b0, bod_off = 1'b0;
  logic pin_n = 1'b1, pin_en = 1'b0;
  logic wdog = 1'b0, wdog_en = 1'b0;
  logic brk = 1'b0, brk_en = 1'b0;
  logic sel = 1'b0, we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic chip_rst;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rst_cause_ctrl #(.SYNC_STAGES(2), .STRETCH_CYCLES(STRETCH)) dut (
    .clk(clk), .pwr_on_i(por), .brownout_i(bod), .brownout_off_i(bod_off),
    .pin_rst_n_i(pin_n), .pin_rst_en_i(pin_en), .wdog_i(wdog), .wdog_en_i(wdog_en),
    .brk_rst_i(brk), .brk_rst_en_i(brk_en), .reg_sel_i(sel), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .chip_rst_o(chip_rst)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    sel = s;
    #1;
    v = rdata;
  endtask

  task automatic wr(input logic s, input logic [7:0] v);
    sel = s; wdata = v; we = 1'b1;
    tick(1);
    we = 1'b0;
  endtask

  task automatic do_por();
    por = 1'b1;
    tick(3);
    por = 1'b0;
    tick(STRETCH + 2);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // drive one source for one cycle; src 0 pin, 1 wdog, 2 brk, 3 brownout
  task automatic pulse(input int src);
    case (src)
      0: pin_n = 1'b0;
      1: wdog = 1'b1;
      2: brk = 1'b1;
      default: bod = 1'b1;
    endcase
    tick(1);
    pin_n = 1'b1; wdog = 1'b0; brk = 1'b0; bod = 1'b0;
  endtask

  initial begin
    #1500000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    logic [7:0] v;
    tick(2);
    // R1: state during power-on
    check("R1 chip_rst in por", {7'b0, chip_rst}, 8'h01);
    rd(1'b0, v); check("R1 cause in por", v, 8'h30);
    rd(1'b1, v); check("R1 ctrl in por", v, 8'h00);
    por = 1'b0;
    tick(STRETCH - 1);
    check("R11 por stretch high", {7'b0, chip_rst}, 8'h01);
    tick(1);
    check("R11 por stretch low", {7'b0, chip_rst}, 8'h00);

    // R3: pin held low across power-on, enabled and disabled
    for (int en = 0; en < 2; en++) begin
      pin_n = 1'b0; pin_en = en[0];
      do_por();
      pin_n = 1'b1;
      tick(STRETCH + 4);
      rd(1'b0, v);
      check("R3 pin low after por", v, en ? 8'h31 : 8'h30);
    end

    // R3 R4 R5 R6: gating sweep, each from a cleared register
    for (int src = 0; src < 4; src++) begin
      for (int en = 0; en < 2; en++) begin
        logic [7:0] bitv;
        pin_en = (src == 0) && en; wdog_en = (src == 1) && en;
        brk_en = (src == 2) && en; bod_off = (src == 3) ? !en : 1'b1;
        bitv = (src == 0) ? 8'h01 : (src == 1) ? 8'h04 : (src == 2) ? 8'h08 : 8'h20;
        do_por();
        wr(1'b0, 8'h00);
        rd(1'b0, v); check("R9 clear all", v, 8'h00);
        pulse(src);
        tick(2);
        check("R11 rst start (R3 R4 R5 R6 gate)", {7'b0, chip_rst}, {7'b0, en[0]});
        rd(1'b0, v); check("R3 R4 R5 R6 flag gate", v, en ? bitv : 8'h00);
        tick(15);
        check("R11 stretch last high", {7'b0, chip_rst}, {7'b0, en[0]});
        tick(1);
        check("R11 stretch end", {7'b0, chip_rst}, 8'h00);
      end
    end
    bod_off = 1'b0;

    // R7: software reset
    do_por();
    wr(1'b1, 8'h01);
    rd(1'b1, v); check("R7 sw bit reads 1", v, 8'h01);
    tick(1);
    rd(1'b1, v); check("R7 sw bit self clears", v, 8'h00);
    check("R7 sw reset active", {7'b0, chip_rst}, 8'h01);
    rd(1'b0, v); check("R7 R8 sw flag kept with por flags", v, 8'h32);
    tick(STRETCH + 2);

    // R10: set wins over clear; R9 write of ones keeps
    wdog_en = 1'b1; wdog = 1'b1;
    tick(4);
    wr(1'b0, 8'h00);
    rd(1'b0, v); check("R10 set beats clear", v, 8'h04);
    wdog = 1'b0;
    tick(STRETCH + 4);
    wr(1'b0, 8'hFF);
    rd(1'b0, v); check("R9 write ones keeps", v, 8'h04);

    // R2 R8 R9: every write value against a full register
    pin_en = 1'b1; brk_en = 1'b1;
    for (int p = 0; p < 256; p++) begin
      do_por();
      pin_n = 1'b0; wdog = 1'b1; brk = 1'b1;
      tick(1);
      pin_n = 1'b1; wdog = 1'b0; brk = 1'b0;
      tick(STRETCH + 4);
      wr(1'b1, 8'h01);
      tick(STRETCH + 3);
      rd(1'b0, v); check("R8 all flags accumulate", v, 8'h3F);
      wr(1'b0, p[7:0]);
      rd(1'b0, v); check("R2 R9 masked clear", v, 8'h3F & p[7:0]);
    end

    report();
  end
endmodule